// File: doc/BRIEF.md
# Sector Lock Retry Sequencer

This block is a host-side controller that locks or unlocks one of the two end sectors of an attached parallel flash device. After a start request naming the end sector (bottom or top) and the direction (lock or unlock), it drives a fixed series of command writes and reads on a simple request/acknowledge bus master port. It then checks the code the device returns after a verify command. A wrong code starts the whole attempt again. After a bounded number of attempts the sequencer gives up and reports failure.

The sequencer sits between a host controller and the flash bus adapter. The adapter turns each request into real bus cycles and raises the acknowledge when the cycle is complete. The sequencer tolerates any number of wait cycles per access. On completion it emits a one-cycle completion pulse, together with a pass flag and the number of attempts used. Both stay readable until the next accepted start.

Top module: `sector_lock_sequencer`

## Requirements
- R1: Out of reset, `bus_req`, `done` and `pass` are low and `attempts` is 0.
- R2: Each attempt begins with six writes, in this order: AAh to 05555h, 55h to 02AAAh, 60h to 05555h, AAh to 05555h, 55h to 02AAAh, then 20h (lock, `unprotect`=0) or 40h (unlock, `unprotect`=1) to the sector address. The sector address has bits [19:15] all zero for `sector_sel`=00000b, all one for 11111b, and every other bit zero.
- R3: After the command write, the attempt continues with five more accesses. First comes one read of the sector address, whose data is ignored. Then come the writes AAh to 05555h, 55h to 02AAAh and 90h to 05555h. Last comes a read of the sector address with bit 1 set and bit 0 clear.
- R4: If the last read returns C2h for a lock or 00h for an unlock, the run ends with `pass`=1 and `attempts` equal to the 1-based number of the attempt.
- R5: Any other returned code starts a new attempt from the first unlock write. If the 25th attempt fails, the run ends with `pass`=0 and `attempts`=25.
- R6: A start whose `sector_sel` is neither all zero nor all one raises `done` in the next cycle, with `pass`=0 and `attempts`=0, and never raises `bus_req`.
- R7: Once a request is presented, `bus_req`, `bus_we`, `bus_addr` and `bus_wdata` hold steady until `bus_ack` is sampled high. Each acknowledged cycle completes exactly one access.
- R8: `done` is high for exactly one cycle. `pass` and `attempts` keep their values until the next accepted start.
- R9: `start`, `unprotect` and `sector_sel` have no effect while a run is in progress. The access series continues with the values captured at the accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start a run (accepted only when idle) |
| unprotect | input | 1 | 0 = lock the sector, 1 = unlock it |
| sector_sel | input | 5 | Sector selector, value of address bits [19:15] |
| bus_req | output | 1 | Access request to the flash bus adapter |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 20 | Access address |
| bus_wdata | output | 8 | Write data |
| bus_ack | input | 1 | Access completed in this cycle |
| bus_rdata | input | 8 | Read data, valid with `bus_ack` on a read |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | Run result, held until the next start |
| attempts | output | 5 | Attempts used, held until the next start |

## Verification
The hardest behaviour to reach from the ports is the give-up path, after exactly 25 failing attempts, together with its neighbour, success on the very last allowed attempt. Both require a device that answers wrongly a chosen number of times. The bench's bus responder counts the lock/unlock command writes it receives. It returns the correct verify code only once that count reaches a per-run target. Sweeping the target over 1, 2, 3, 7, 25 and 26 for both directions, both sectors and several acknowledge latencies covers both limits, and a start toggled mid-run with the opposite direction checks that the run ignores it.

// File: rtl/slq_pkg.sv
`timescale 1ns/1ps
package slq_pkg;

    localparam int ADDR_W        = 20;
    localparam int DATA_W        = 8;
    localparam int SEC_LSB       = 15;
    localparam int SEC_W         = ADDR_W - SEC_LSB;
    localparam int DEF_MAX_TRIES = 25;
    localparam int NUM_STEPS     = 11;
    localparam int STEP_W        = $clog2(NUM_STEPS);

    localparam logic [ADDR_W-1:0] UNLK_ADDR_A = 20'h05555;
    localparam logic [ADDR_W-1:0] UNLK_ADDR_B = 20'h02AAA;
    localparam logic [ADDR_W-1:0] VFY_OFFSET  = 20'h00002;

    localparam logic [DATA_W-1:0] KEY_FIRST   = 8'hAA;
    localparam logic [DATA_W-1:0] KEY_SECOND  = 8'h55;
    localparam logic [DATA_W-1:0] CMD_SETUP   = 8'h60;
    localparam logic [DATA_W-1:0] CMD_LOCK    = 8'h20;
    localparam logic [DATA_W-1:0] CMD_UNLOCK  = 8'h40;
    localparam logic [DATA_W-1:0] CMD_VERIFY  = 8'h90;
    localparam logic [DATA_W-1:0] CODE_LOCKED = 8'hC2;
    localparam logic [DATA_W-1:0] CODE_FREE   = 8'h00;

    // access slots of one attempt; order is the device protocol
    localparam logic [STEP_W-1:0] STP_KEY1_A  = 4'd0;
    localparam logic [STEP_W-1:0] STP_KEY2_A  = 4'd1;
    localparam logic [STEP_W-1:0] STP_SETUP   = 4'd2;
    localparam logic [STEP_W-1:0] STP_KEY1_B  = 4'd3;
    localparam logic [STEP_W-1:0] STP_KEY2_B  = 4'd4;
    localparam logic [STEP_W-1:0] STP_ACTION  = 4'd5;
    localparam logic [STEP_W-1:0] STP_STATUS  = 4'd6;
    localparam logic [STEP_W-1:0] STP_KEY1_V  = 4'd7;
    localparam logic [STEP_W-1:0] STP_KEY2_V  = 4'd8;
    localparam logic [STEP_W-1:0] STP_VCMD    = 4'd9;
    localparam logic [STEP_W-1:0] STP_VREAD   = 4'd10;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_BUS  = 1'b1
    } seq_state_t;

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } bus_access_t;

    function automatic logic sel_is_legal(input logic [SEC_W-1:0] sel);
        return (&sel) || !(|sel);
    endfunction

    function automatic logic [ADDR_W-1:0] sector_base(input logic [SEC_W-1:0] sel);
        return {sel, {SEC_LSB{1'b0}}};
    endfunction

    function automatic logic [DATA_W-1:0] wanted_code(input logic unlock);
        return unlock ? CODE_FREE : CODE_LOCKED;
    endfunction

endpackage

// File: rtl/slq_step_ctr.sv
`timescale 1ns/1ps
module slq_step_ctr
    import slq_pkg::*;
#(
    parameter int STEPS = NUM_STEPS,
    localparam int W    = $clog2(STEPS)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         advance,
    output logic [W-1:0] step,
    output logic         last
);
    always_ff @(posedge clk) begin
        if (rst) begin
            step <= '0;
        end else if (clear) begin
            step <= '0;
        end else if (advance && !last) begin
            step <= step + W'(1);
        end
    end

    assign last = (step == W'(STEPS - 1));
endmodule

// File: rtl/slq_try_ctr.sv
`timescale 1ns/1ps
module slq_try_ctr #(
    parameter int LIMIT = 25,
    localparam int W    = $clog2(LIMIT + 1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         load_one,
    input  logic         inc,
    output logic [W-1:0] count,
    output logic         at_limit
);
    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (clear) begin
            count <= '0;
        end else if (load_one) begin
            count <= W'(1);
        end else if (inc && !at_limit) begin
            count <= count + W'(1);
        end
    end

    assign at_limit = (count == W'(LIMIT));
endmodule

// File: rtl/slq_cmd_gen.sv
`timescale 1ns/1ps
module slq_cmd_gen
    import slq_pkg::*;
(
    input  logic [STEP_W-1:0] step,
    input  logic              unlock,
    input  logic [SEC_W-1:0]  sel,
    output bus_access_t       acc
);
    logic [ADDR_W-1:0] base;

    always_comb begin
        base = sector_base(sel);
        acc  = '0;
        unique case (step)
            STP_KEY1_A, STP_KEY1_B, STP_KEY1_V:
                acc = '{we: 1'b1, addr: UNLK_ADDR_A, data: KEY_FIRST};
            STP_KEY2_A, STP_KEY2_B, STP_KEY2_V:
                acc = '{we: 1'b1, addr: UNLK_ADDR_B, data: KEY_SECOND};
            STP_SETUP:
                acc = '{we: 1'b1, addr: UNLK_ADDR_A, data: CMD_SETUP};
            STP_ACTION:
                acc = '{we: 1'b1, addr: base, data: unlock ? CMD_UNLOCK : CMD_LOCK};
            STP_STATUS:
                acc = '{we: 1'b0, addr: base, data: '0};
            STP_VCMD:
                acc = '{we: 1'b1, addr: UNLK_ADDR_A, data: CMD_VERIFY};
            STP_VREAD:
                acc = '{we: 1'b0, addr: base | VFY_OFFSET, data: '0};
            default:
                acc = '0;
        endcase
    end
endmodule

// File: rtl/sector_lock_sequencer.sv
`timescale 1ns/1ps
module sector_lock_sequencer
    import slq_pkg::*;
#(
    parameter int MAX_TRIES = DEF_MAX_TRIES,
    localparam int TRY_W    = $clog2(MAX_TRIES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              unprotect,
    input  logic [SEC_W-1:0]  sector_sel,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              done,
    output logic              pass,
    output logic [TRY_W-1:0]  attempts
);
    seq_state_t        state_q;
    logic              unlock_q;
    logic [SEC_W-1:0]  sel_q;
    logic              done_q;
    logic              pass_q;

    logic              start_ok;
    logic              sel_ok;
    logic              xfer;
    logic              final_xfer;
    logic              code_ok;
    logic              hit;
    logic              retry;
    logic              give_up;
    logic              step_last;
    logic              at_limit;
    logic [STEP_W-1:0] step;
    bus_access_t       cur;

    assign start_ok   = start && (state_q == ST_IDLE);
    assign sel_ok     = sel_is_legal(sector_sel);
    assign xfer       = (state_q == ST_BUS) && bus_ack;
    assign final_xfer = xfer && step_last;
    assign code_ok    = (bus_rdata == wanted_code(unlock_q));
    assign hit        = final_xfer && code_ok;
    assign retry      = final_xfer && !code_ok && !at_limit;
    assign give_up    = final_xfer && !code_ok && at_limit;

    slq_step_ctr #(.STEPS(NUM_STEPS)) u_step (
        .clk     (clk),
        .rst     (rst),
        .clear   (start_ok || retry),
        .advance (xfer),
        .step    (step),
        .last    (step_last)
    );

    slq_try_ctr #(.LIMIT(MAX_TRIES)) u_try (
        .clk      (clk),
        .rst      (rst),
        .clear    (start_ok && !sel_ok),
        .load_one (start_ok && sel_ok),
        .inc      (retry),
        .count    (attempts),
        .at_limit (at_limit)
    );

    slq_cmd_gen u_cmd (
        .step   (step),
        .unlock (unlock_q),
        .sel    (sel_q),
        .acc    (cur)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            unlock_q <= 1'b0;
            sel_q    <= '0;
            done_q   <= 1'b0;
            pass_q   <= 1'b0;
        end else begin
            done_q <= (start_ok && !sel_ok) || hit || give_up;
            if (start_ok) begin
                unlock_q <= unprotect;
                sel_q    <= sector_sel;
                pass_q   <= 1'b0;
                if (sel_ok) begin
                    state_q <= ST_BUS;
                end
            end else if (hit) begin
                pass_q  <= 1'b1;
                state_q <= ST_IDLE;
            end else if (give_up) begin
                state_q <= ST_IDLE;
            end
        end
    end

    assign bus_req   = (state_q == ST_BUS);
    assign bus_we    = cur.we;
    assign bus_addr  = cur.addr;
    assign bus_wdata = cur.data;
    assign done      = done_q;
    assign pass      = pass_q;
endmodule

// File: rtl/slq_checker.sv
`timescale 1ns/1ps
module slq_checker
    import slq_pkg::*;
#(
    parameter int MAX_TRIES = DEF_MAX_TRIES,
    localparam int TRY_W    = $clog2(MAX_TRIES + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic [SEC_W-1:0]  sector_sel,
    input logic              bus_req,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_ack,
    input logic              done,
    input logic              pass,
    input logic [TRY_W-1:0]  attempts
);
    // R7: a pending request keeps all its fields until acknowledged
    assert_req_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_we) &&
                                   $stable(bus_addr) && $stable(bus_wdata)));

    // R8: completion pulse lasts one cycle
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8: results stay put between completion and the next start
    assert_result_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!done && !bus_req && !$past(start)) |-> ($stable(pass) && $stable(attempts)));

    // R6: illegal selector finishes at once as a failure with no bus traffic
    assert_bad_sel_R6: assert property (@(posedge clk) disable iff (rst)
        (start && !bus_req && !((&sector_sel) || !(|sector_sel)))
        |=> (done && !pass && attempts == '0 && !bus_req));

    // R5: a failed run used exactly the full attempt budget
    assert_fail_count_R5: assert property (@(posedge clk) disable iff (rst)
        (done && !pass && attempts != '0) |-> (attempts == TRY_W'(MAX_TRIES)));

    // R4: a passing run used at least one and at most the budget
    assert_pass_count_R4: assert property (@(posedge clk) disable iff (rst)
        (done && pass) |-> (attempts != '0 && attempts <= TRY_W'(MAX_TRIES)));

    // R2: the lock/unlock command only ever targets an end sector
    assert_action_sector_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_we && (bus_wdata == CMD_LOCK || bus_wdata == CMD_UNLOCK))
        |-> ((&bus_addr[ADDR_W-1:SEC_LSB]) || !(|bus_addr[ADDR_W-1:SEC_LSB])));

    // R8: completion never overlaps an outstanding request
    assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> !bus_req);
endmodule

bind sector_lock_sequencer slq_checker #(.MAX_TRIES(MAX_TRIES)) u_slq_checker (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .sector_sel (sector_sel),
    .bus_req    (bus_req),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_ack    (bus_ack),
    .done       (done),
    .pass       (pass),
    .attempts   (attempts)
);

// File: tb/tb_sector_lock_sequencer.sv
`timescale 1ns/1ps
module tb_sector_lock_sequencer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        unprotect = 1'b0;
    logic [4:0]  sector_sel = 5'd0;
    logic        bus_req;
    logic        bus_we;
    logic [19:0] bus_addr;
    logic [7:0]  bus_wdata;
    logic        bus_ack = 1'b0;
    logic [7:0]  bus_rdata = 8'h00;
    logic        done;
    logic        pass;
    logic [4:0]  attempts;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    // responder configuration and bookkeeping
    int   lat      = 0;
    int   need     = 1;
    logic run_op   = 1'b0;
    logic [4:0] run_sel = 5'd0;
    int   idx      = 0;
    int   pulses   = 0;
    int   acc_cnt  = 0;
    int   wait_cnt = 0;

    always #2 clk = ~clk;

    sector_lock_sequencer dut (
        .clk(clk), .rst(rst), .start(start), .unprotect(unprotect),
        .sector_sel(sector_sel), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
        .bus_rdata(bus_rdata), .done(done), .pass(pass), .attempts(attempts)
    );

    task automatic check(input logic ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // expected access k of an attempt, built from R2 and R3
    task automatic expect_acc(input int k, input logic op, input logic [4:0] sel,
                              output logic we, output logic [19:0] a, output logic [7:0] d);
        logic [19:0] sa;
        sa = {sel, 15'd0};
        we = 1'b1; d = 8'h00; a = 20'h05555;
        case (k)
            0, 3, 7: begin a = 20'h05555; d = 8'hAA; end
            1, 4, 8: begin a = 20'h02AAA; d = 8'h55; end
            2:       begin a = 20'h05555; d = 8'h60; end
            5:       begin a = sa; d = op ? 8'h40 : 8'h20; end
            6:       begin we = 1'b0; a = sa; end
            9:       begin a = 20'h05555; d = 8'h90; end
            default: begin we = 1'b0; a = sa | 20'd2; end
        endcase
    endtask

    // bus responder: ack after lat waiting cycles, checks each access
    initial begin
        forever begin
            @(negedge clk);
            bus_ack = 1'b0;
            if (bus_req) begin
                if (wait_cnt >= lat) begin
                    logic ew;
                    logic [19:0] ea;
                    logic [7:0] ed;
                    wait_cnt = 0;
                    expect_acc(idx, run_op, run_sel, ew, ea, ed);
                    if (idx <= 5)
                        check(bus_we == ew && bus_addr == ea && (!ew || bus_wdata == ed),
                              "R2", "attempt access", {bus_we, bus_addr, bus_wdata}, {ew, ea, ed});
                    else
                        check(bus_we == ew && bus_addr == ea && (!ew || bus_wdata == ed),
                              "R3", "verify access", {bus_we, bus_addr, bus_wdata}, {ew, ea, ed});
                    if (idx == 5) pulses++;
                    if (idx == 10)
                        bus_rdata = (pulses >= need) ? (run_op ? 8'h00 : 8'hC2)
                                                     : (run_op ? 8'hC2 : 8'h00);
                    else
                        bus_rdata = 8'h80;
                    idx = (idx == 10) ? 0 : idx + 1;
                    acc_cnt++;
                    bus_ack = 1'b1;
                end else begin
                    wait_cnt++;
                end
            end
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 190000) begin
                check(1'b0, "R7", "watchdog expired", cycles, 190000);
                summary();
            end
        end
    end

    task automatic run(input logic op, input logic [4:0] sel, input int n,
                       input int l, input logic poke);
        int  exp_att;
        logic exp_pass;
        bit  seen = 0;
        lat = l; need = n; run_op = op; run_sel = sel;
        idx = 0; pulses = 0; acc_cnt = 0; wait_cnt = 0;
        exp_pass = (n <= 25);
        exp_att  = exp_pass ? n : 25;
        @(negedge clk);
        start = 1'b1; unprotect = op; sector_sel = sel;
        @(negedge clk);
        start = 1'b0;
        for (int c = 0; c < 4000; c++) begin
            if (done) begin seen = 1; break; end
            if (poke && c == 4) begin
                start = 1'b1; unprotect = ~op; sector_sel = ~sel;
            end
            if (poke && c == 5) start = 1'b0;
            @(negedge clk);
        end
        check(seen, "R8", "done seen", seen, 1);
        check(pass == exp_pass, exp_pass ? "R4" : "R5", "pass", pass, exp_pass);
        check(attempts == 5'(exp_att), exp_pass ? "R4" : "R5", "attempts", attempts, exp_att);
        check(acc_cnt == exp_att * 11, "R5", "access count", acc_cnt, exp_att * 11);
        if (poke) check(acc_cnt == exp_att * 11 && pass == exp_pass, "R9",
                        "start during run ignored", acc_cnt, exp_att * 11);
        @(negedge clk);
        check(!done, "R8", "done one cycle", done, 0);
        check(pass == exp_pass && attempts == 5'(exp_att), "R8", "results held",
              {pass, attempts}, {exp_pass, 5'(exp_att)});
        check(!bus_req, "R7", "idle after run", bus_req, 0);
    endtask

    initial begin
        int ns[6] = '{1, 2, 3, 7, 25, 26};
        repeat (3) @(negedge clk);
        check(!bus_req && !done && !pass && attempts == 5'd0, "R1", "reset state",
              {bus_req, done, pass, attempts}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!bus_req && !done && !pass && attempts == 5'd0, "R1", "after reset release",
              {bus_req, done, pass, attempts}, 0);

        for (int op = 0; op < 2; op++)
            for (int s = 0; s < 2; s++)
                for (int k = 0; k < 6; k++)
                    for (int l = 0; l < 3; l++)
                        run(op[0], s[0] ? 5'h1F : 5'h00, ns[k], l, (k == 1 && l == 1));

        // R6: every illegal selector value, both directions
        for (int op = 0; op < 2; op++)
            for (int s = 1; s < 31; s++) begin
                acc_cnt = 0;
                @(negedge clk);
                start = 1'b1; unprotect = op[0]; sector_sel = 5'(s);
                @(negedge clk);
                start = 1'b0;
                check(done && !pass && attempts == 5'd0 && !bus_req, "R6", "illegal selector",
                      {done, pass, attempts, bus_req}, 8'h80);
                @(negedge clk);
                check(!done && !bus_req, "R6", "illegal selector after", {done, bus_req}, 0);
                @(negedge clk);
                check(acc_cnt == 0, "R6", "no bus access", acc_cnt, 0);
            end

        summary();
    end
endmodule